// File: doc/BRIEF.md
# Two-Wire Bus Slave Transmit Engine

This block is the slave side of a two-wire serial bus (I2C/SMBus) that answers read requests. It watches the already filtered clock and data lines and finds START and STOP conditions. It collects the 7-bit address and direction bit that follow a START. When the address is its own and the master wants to read, it hands control to software through an interrupt flag and an acknowledge-request flag. Software then chooses whether to acknowledge the address and supplies each byte. The engine drives those bytes onto the data line through an open-drain pull-down.

Software handshakes at every event. While the interrupt flag is up, the engine stretches the bus clock by pulling SCL low. It lets SCL go one cycle after software clears the flag. The data-byte interrupt fires only after the master's acknowledge clock. If software clears a data interrupt without writing a byte, the engine falls back to passive receive mode. If software writes a byte after the master has refused one, an error flag is raised.

Top module: `smbus_slave_tx`

## Requirements
- R1: A START is SDA falling while SCL stays high. In every state, a START sends the engine to address reception with a cleared bit count, and it clears the error flag.
- R2: Address bits are sampled on SCL rising edges, MSB first. Bits 7..1 are compared with `own_addr`, and bit 0 equal to 1 means READ. On a match with READ, the SCL falling edge that ends the eighth bit raises `flag` and `ack_req`. A mismatch or a WRITE leaves `flag` low and SDA released.
- R3: While `ignore_addr` is 1 when the address completes, no interrupt is raised and SDA is not driven.
- R4: Whenever `flag` is 1, `scl_pull` is 1. After a `flag_clr` pulse, `flag` reads 0 one cycle later and `scl_pull` drops one cycle after that.
- R5: If software clears the address interrupt with `ack_sel`=1, SDA is pulled low through the ninth clock. If it clears with `ack_sel`=0, SDA stays released and no further interrupt comes until the next START.
- R6: A byte written on `data_in`/`data_wr` is driven MSB first: `sda_pull`=1 for a 0 bit and 0 for a 1 bit. `sda_pull` changes only while SCL is low.
- R7: After eight data bits SDA is released for the ninth clock. The master's bit is sampled on its rising edge, and `master_ack`=1 means ACK (SDA low). `flag` rises on the SCL fall that ends that ninth clock.
- R8: A `data_wr` while `flag` is 1 after a master NACK sets `tx_error`. The flag stays set until the next START, and the written byte is discarded.
- R9: If a data interrupt that followed a master ACK is cleared without a byte written, the engine leaves transmit mode (`tx_active`=0) and releases SDA. It raises no interrupt until START or STOP. The same fallback applies when no byte is pending at the end of the address ACK.
- R10: After a master NACK the engine stays in transmit mode with SDA released, and a STOP (SDA rising while SCL is high) returns it to idle with `tx_active`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Synchronised bus clock level |
| sda_in | input | 1 | Synchronised bus data level |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low |
| ignore_addr | input | 1 | 1 makes the engine ignore addressing |
| own_addr | input | ADDR_W | Own slave address |
| ack_sel | input | 1 | Address answer when the flag is cleared: 1 ACK, 0 NACK |
| data_wr | input | 1 | One-cycle write strobe for the transmit byte |
| data_in | input | DATA_W | Transmit byte |
| flag_clr | input | 1 | One-cycle strobe that clears the interrupt flag |
| flag | output | 1 | Interrupt flag |
| ack_req | output | 1 | Address acknowledge requested from software |
| master_ack | output | 1 | Last master acknowledge bit: 1 ACK, 0 NACK |
| tx_error | output | 1 | Write after master NACK seen |
| tx_active | output | 1 | Engine is in transmit mode |

## Verification
Bus events are found in the same cycle the changed line level arrives, so the flag rises one clock after the SCL fall that ends an address or acknowledge clock. A flag clear shows one cycle later on `flag` and two cycles later on `scl_pull`. The error flag shows one cycle after the offending write. The bench's software model waits three cycles after it sees the flag and then checks the stretch. It checks the flag one cycle after its clear pulse, the release one cycle after that, and the error right after the write pulse. The master model samples SDA two cycles into each high SCL phase, long after the slave's data has settled in the low phase.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // waiting for START
    ST_ADDR,   // collecting address and direction
    ST_AWAIT,  // address interrupt pending
    ST_AACK,   // driving address ACK on ninth clock
    ST_TX,     // shifting a byte out
    ST_TACK,   // master acknowledge clock
    ST_TWAIT,  // data interrupt pending
    ST_TEND,   // transmit after master NACK, wait STOP
    ST_RX,     // passive receive fallback
    ST_INHIB   // addressing inhibited until START
  } smbt_state_e;

  // Address match and read direction for a received address byte.
  function automatic logic addr_read_hit(input logic [7:0] rx, input logic [6:0] own);
    return (rx[7:1] == own) && rx[0];
  endfunction
endpackage

// File: rtl/smbt_bus_events.sv
module smbt_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;

  p_start_stop_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o));
  p_edge_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o));
endmodule

// File: rtl/smbt_addr_shift.sv
module smbt_addr_shift #(
  parameter int ADDR_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            rise_i,
  input  logic            sda_i,
  output logic [ADDR_W:0] byte_o,
  output logic            full_o
);
  localparam int NBITS = ADDR_W + 1;
  localparam int CW    = $clog2(NBITS + 1);

  logic [CW-1:0] cnt;

  assign full_o = (cnt == CW'(NBITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      byte_o <= '0;
    end else if (clear_i) begin
      cnt    <= '0;
    end else if (rise_i && !full_o) begin
      byte_o <= {byte_o[ADDR_W-1:0], sda_i};
      cnt    <= cnt + 1'b1;
    end
  end

  p_addr_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(NBITS));
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt == '0));
endmodule

// File: rtl/smbt_tx_shift.sv
module smbt_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int CW = $clog2(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [CW-1:0]     cnt;

  assign bit_o  = sh[DATA_W-1];
  assign last_o = shift_i && (cnt == CW'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
    end else if (load_i) begin
      sh  <= data_i;
      cnt <= '0;
    end else if (shift_i) begin
      sh  <= {sh[DATA_W-2:0], 1'b1};
      cnt <= cnt + 1'b1;
    end
  end

  p_load_msb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (bit_o == $past(data_i[DATA_W-1])));
endmodule

// File: rtl/smbus_slave_tx.sv
module smbus_slave_tx #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              ignore_addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_sel,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              flag_clr,
  output logic              flag,
  output logic              ack_req,
  output logic              master_ack,
  output logic              tx_error,
  output logic              tx_active
);
  import smbt_pkg::*;

  smbt_state_e       st;
  logic              start_evt, stop_evt, scl_rise, scl_fall;
  logic [ADDR_W:0]   addr_byte;
  logic              addr_full, addr_hit;
  logic              tx_bit, tx_last, tx_load, tx_shift;
  logic              flag_d, loaded, nack_write;
  logic [DATA_W-1:0] data_q;

  smbt_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
    .start_o(start_evt), .stop_o(stop_evt),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  smbt_addr_shift #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clear_i(start_evt),
    .rise_i(scl_rise && st == ST_ADDR), .sda_i(sda_in),
    .byte_o(addr_byte), .full_o(addr_full)
  );

  smbt_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load_i(tx_load), .data_i(data_q),
    .shift_i(tx_shift), .bit_o(tx_bit), .last_o(tx_last)
  );

  assign addr_hit   = (addr_byte[ADDR_W:1] == own_addr) && addr_byte[0];
  assign tx_shift   = scl_fall && (st == ST_TX) && !start_evt && !stop_evt;
  assign tx_load    = !start_evt && !stop_evt && loaded &&
                      (((st == ST_AACK) && scl_fall) ||
                       ((st == ST_TWAIT) && flag_clr && master_ack));
  assign nack_write = data_wr && (st == ST_TWAIT) && flag && !master_ack;

  assign scl_pull  = flag | flag_d;
  assign sda_pull  = (st == ST_AACK) || ((st == ST_TX) && !tx_bit);
  assign tx_active = (st == ST_TX) || (st == ST_TACK) ||
                     (st == ST_TWAIT) || (st == ST_TEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      flag       <= 1'b0;
      flag_d     <= 1'b0;
      ack_req    <= 1'b0;
      master_ack <= 1'b0;
      tx_error   <= 1'b0;
      loaded     <= 1'b0;
      data_q     <= '0;
    end else begin
      flag_d <= flag;
      if (start_evt) begin
        st       <= ST_ADDR;
        flag     <= 1'b0;
        ack_req  <= 1'b0;
        tx_error <= 1'b0;
      end else if (stop_evt) begin
        st      <= ST_IDLE;
        flag    <= 1'b0;
        ack_req <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: if (scl_fall && addr_full) begin
            if (!ignore_addr && addr_hit) begin
              flag    <= 1'b1;
              ack_req <= 1'b1;
              st      <= ST_AWAIT;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_AWAIT: if (flag_clr) begin
            flag    <= 1'b0;
            ack_req <= 1'b0;
            st      <= ack_sel ? ST_AACK : ST_INHIB;
          end
          ST_AACK: if (scl_fall) st <= tx_load ? ST_TX : ST_RX;
          ST_TX:   if (tx_last) st <= ST_TACK;
          ST_TACK: begin
            if (scl_rise) master_ack <= ~sda_in;
            if (scl_fall) begin
              flag <= 1'b1;
              st   <= ST_TWAIT;
            end
          end
          ST_TWAIT: if (flag_clr) begin
            flag <= 1'b0;
            if (!master_ack)  st <= ST_TEND;
            else if (tx_load) st <= ST_TX;
            else              st <= ST_RX;
          end
          default: ;
        endcase
      end
      if (tx_load || start_evt || stop_evt) loaded <= 1'b0;
      if (data_wr) begin
        if (nack_write) begin
          tx_error <= 1'b1;
        end else begin
          data_q <= data_in;
          loaded <= 1'b1;
        end
      end
    end
  end

  p_start_enters_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_ADDR));
  p_irq_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(st) == ST_ADDR || $past(st) == ST_TACK));
  p_inhibit_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && ignore_addr) |=> !flag);
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && flag_clr && !start_evt && !stop_evt) |=> scl_pull ##1 !scl_pull);
  p_inhib_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INHIB && !start_evt) |=> (!flag && !sda_pull));
  p_sda_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && $past(scl_in) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_pull));
  p_ack_clock_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TACK) |-> !sda_pull);
  p_err_after_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_error) |-> !master_ack);
  p_rx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX) |-> (!sda_pull && !tx_active));
  p_stop_leaves_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> !tx_active);
endmodule

// File: tb/smbus_slave_tx_bench.sv
module smbus_slave_tx_bench;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull;
  logic ignore_addr = 1'b0;
  logic [6:0] own_addr = 7'h2C;
  logic ack_sel = 1'b0, data_wr = 1'b0, flag_clr = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic flag, ack_req, master_ack, tx_error, tx_active;
  wire scl_bus = scl_m & ~scl_pull;
  wire sda_bus = sda_m & ~sda_pull;

  smbus_slave_tx u_smbus_slave_tx (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .ignore_addr(ignore_addr),
    .own_addr(own_addr), .ack_sel(ack_sel), .data_wr(data_wr),
    .data_in(data_in), .flag_clr(flag_clr), .flag(flag), .ack_req(ack_req),
    .master_ack(master_ack), .tx_error(tx_error), .tx_active(tx_active)
  );

  int n_checks = 0, n_fail = 0;
  int irq_idx = 0, cur_n = 0, sw_nwrite = 0, sda_glitch = 0;
  logic sw_ack = 1'b1, sw_bad = 1'b0;
  logic [7:0] tdata [8];
  logic prev_scl = 1'b1, prev_sda = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_irqs(input logic hit, input logic ack, input int n, input int nw);
    if (!hit) return 0;
    if (!ack) return 1;
    return 1 + ((nw < n) ? nw : n);
  endfunction

  function automatic logic [7:0] exp_byte(input logic hit, input logic ack, input int i, input int nw);
    return (hit && ack && i < nw) ? tdata[i] : 8'hFF;
  endfunction

  // R6: monitor for SDA drive changes while SCL is high
  always @(negedge clk) begin
    if (rst_n && scl_bus && prev_scl && sda_pull != prev_sda) sda_glitch++;
    prev_scl = scl_bus;
    prev_sda = sda_pull;
  end

  task automatic wr_byte(input logic [7:0] b);
    data_in = b; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic sw_service;
    int k;
    logic exp_ack;
    k = irq_idx;
    exp_ack = 1'b1;
    repeat (3) @(negedge clk);
    check(scl_pull == 1'b1, "R4 stretch", scl_pull, 1);
    if (k == 0) begin
      check(ack_req == 1'b1, "R2 ack_req", ack_req, 1);
      ack_sel = sw_ack;
      if (sw_ack && sw_nwrite > 0) wr_byte(tdata[0]);
    end else begin
      exp_ack = (k < cur_n);
      check(master_ack == exp_ack, "R7 master_ack", master_ack, exp_ack);
      check(ack_req == 1'b0, "R7 no ack_req", ack_req, 0);
      if (exp_ack && k < sw_nwrite) wr_byte(tdata[k]);
      else if (!exp_ack && sw_bad) begin
        wr_byte(8'h5A);
        check(tx_error == 1'b1, "R8 error set", tx_error, 1);
      end
    end
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check(flag == 1'b0 && scl_pull == 1'b1, "R4 clear", {flag, scl_pull}, 1);
    @(negedge clk);
    check(scl_pull == 1'b0, "R4 release", scl_pull, 0);
    if (k > 0 && !exp_ack) check(tx_active == 1'b1, "R10 tx after nack", tx_active, 1);
    if (k > 0 && exp_ack && k >= sw_nwrite)
      check(tx_active == 1'b0 && sda_pull == 1'b0, "R9 fallback", {tx_active, sda_pull}, 0);
    irq_idx++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && flag) sw_service();
    end
  end

  task automatic wait_cycles(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic scl_up;
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wait_cycles(H);
    scl_up(); wait_cycles(H);
    scl_m = 1'b0; wait_cycles(1);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wait_cycles(H);
    scl_up(); wait_cycles(2);
    b = sda_bus; wait_cycles(H - 2);
    scl_m = 1'b0; wait_cycles(1);
  endtask

  task automatic m_start;
    sda_m = 1'b1; scl_m = 1'b1; wait_cycles(H);
    sda_m = 1'b0; wait_cycles(H);
    scl_m = 1'b0; wait_cycles(H);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wait_cycles(H);
    scl_up(); wait_cycles(H);
    sda_m = 1'b1; wait_cycles(H);
  endtask

  // One full read transaction with master and software expectations
  task automatic xact(input logic [6:0] a, input logic rd, input logic inh,
                      input logic ack, input int n, input int nw, input logic bad,
                      input string tag);
    logic hit, b, exp_err;
    logic [7:0] rx, ab;
    ignore_addr = inh; sw_ack = ack; cur_n = n; sw_nwrite = nw; sw_bad = bad;
    irq_idx = 0;
    for (int i = 0; i < 8; i++) tdata[i] = 8'($urandom);
    hit = (a == own_addr) && rd && !inh;
    exp_err = hit && ack && nw >= n && bad;
    ab = {a, rd};
    m_start();
    for (int i = 7; i >= 0; i--) bit_out(ab[i]);
    bit_in(b);
    check(b == !(hit && ack), {tag, " addr ack"}, b, !(hit && ack));
    for (int j = 0; j < n; j++) begin
      for (int i = 7; i >= 0; i--) begin
        bit_in(b);
        rx[i] = b;
      end
      check(rx == exp_byte(hit, ack, j, nw), "R6 data byte", rx, exp_byte(hit, ack, j, nw));
      bit_out(j == n - 1);
    end
    m_stop();
    wait_cycles(2);
    check(irq_idx == exp_irqs(hit, ack, n, nw), {tag, " irq count"}, irq_idx, exp_irqs(hit, ack, n, nw));
    check(tx_error == exp_err, "R8 error flag", tx_error, exp_err);
    check(tx_active == 1'b0, "R10 idle after stop", tx_active, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7301);
    wait_cycles(4);
    check(scl_pull == 0 && sda_pull == 0 && flag == 0 && tx_error == 0 && tx_active == 0,
          "R1 reset state", {scl_pull, sda_pull, flag, tx_error, tx_active}, 0);
    rst_n = 1'b1;
    wait_cycles(4);
    xact(7'h2C, 1, 0, 1, 2, 2, 0, "R2 match read");
    xact(7'h2C, 1, 1, 1, 1, 1, 0, "R3 inhibit");
    xact(7'h2D, 1, 0, 1, 1, 1, 0, "R2 mismatch");
    xact(7'h2C, 0, 0, 1, 1, 1, 0, "R2 write dir");
    xact(7'h2C, 1, 0, 0, 2, 2, 0, "R5 addr nack");
    xact(7'h2C, 1, 0, 1, 3, 3, 0, "R1 start after inhibit");
    xact(7'h2C, 1, 0, 1, 3, 1, 0, "R9 missing write");
    xact(7'h2C, 1, 0, 1, 2, 0, 0, "R9 no first byte");
    xact(7'h2C, 1, 0, 1, 2, 2, 1, "R8 bad write");
    xact(7'h2C, 1, 0, 1, 1, 1, 0, "R7 single byte");
    for (int t = 0; t < 24; t++) begin
      logic [6:0] a;
      int n, nw;
      own_addr = 7'($urandom);
      a = ($urandom_range(0, 3) != 0) ? own_addr : own_addr ^ 7'($urandom_range(1, 127));
      n = $urandom_range(1, 4);
      nw = ($urandom_range(0, 3) != 0) ? n : $urandom_range(0, n - 1);
      xact(a, $urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 7) != 0, n, nw, $urandom_range(0, 3) == 0, "R2 random");
    end
    check(sda_glitch == 0, "R6 sda steady while scl high", sda_glitch, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule